// File: doc/BRIEF.md
# Data Access Translation Fault Prioritizer

This block sits between a load/store unit and a translation buffer. For each data request it decides, in one fixed order of checks, whether the access faults, which kind of fault it is, and which memory-management status bits go with it. When the access is allowed it also produces the physical address. The physical address comes from one of three places: the virtual address itself in physical mode, a direct superpage window, or a buffer hit.

The buffer storage is not part of the block. The block presents the virtual page number on `tbVpn`. In the same cycle the surrounding logic returns the hit flag, the physical page number, the per-mode read and write enable masks, and the fault-on-read and fault-on-write bits of the matching entry. Requests are accepted every cycle. Each result is registered and appears on the clock edge after the request.

Top module: `dtb_fault_prioritizer`

## Requirements
- R1: After reset `rspValid` is 0, `fault` is 0 (none), and `status` and `paddr` are 0. Each cycle with `reqValid` high gives `rspValid` high one clock later, with that request's result.
- R2: Alignment is checked before anything else. The access size is `sizeLog2` (0=1, 1=2, 2=4, 3=8 bytes). Any set address bit below the size raises fault 1 (alignment). Its status holds only bit 0 (write), and only for stores.
- R3: With `physMode` set and no alignment fault, the physical address equals the virtual address. No validity, superpage or buffer check applies.
- R4: A virtual address is invalid when bits 63:43 are not all equal to bit 42. It raises fault 2 (page fault) with status bit 2 (bad address) and bit 1 (access violation), plus bit 0 for stores.
- R5: An address whose bits 47:41 equal 0x7e is a superpage access. It is allowed only when `curMode` is kernel (mode 0), whatever the privileged-code override says. Otherwise it raises fault 3 (access violation) with status bit 1, plus bit 0 for stores.
- R6: The superpage physical address keeps virtual bits 39:0. Bits 43:40 are all ones if virtual bit 40 is set and all zeros if it is clear. Every bit above 43 is zero.
- R7: A buffer miss raises fault 5 (page-table miss) when `pteAccess` is set and fault 4 (normal miss) when it is not. The status holds bit 3 (miss), plus bit 0 for stores.
- R8: On a hit the physical address is `tbPpn` shifted left by 13, OR-ed with virtual bits 12:0. `tbVpn` carries virtual bits 63:13.
- R9: On a store hit, a clear write-enable bit for the effective mode raises fault 2 with status bits 0 and 1, plus bit 5 when fault-on-write is set. Otherwise, fault-on-write set raises fault 2 with status bits 0 and 5.
- R10: On a load hit, a clear read-enable bit for the effective mode raises fault 3 with status bit 1, plus bit 4 when fault-on-read is set. Otherwise, fault-on-read set raises fault 2 with status bit 4. A load never sets status bit 0.
- R11: Modes are 2-bit values: kernel 0, executive 1, supervisor 2, user 3. The enable masks are indexed by mode. With `palCode` set, the effective mode is `altMode` if `altSel` is set and kernel if it is not. Without `palCode`, the effective mode is `curMode`.
- R12: If an allowed translation yields a physical address with any bit at 44 or above set, fault 6 (machine check) is raised with a status of 0.
- R13: `paddr` is 0 whenever `fault` is not 0. The fault-on bit of the opposite direction (fault-on-read for stores, fault-on-write for loads) has no effect when the access is otherwise permitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| vaddr | input | 64 | Virtual address |
| sizeLog2 | input | 2 | Log2 of the access size in bytes |
| isWrite | input | 1 | Store when 1, load when 0 |
| physMode | input | 1 | Treat the address as physical |
| palCode | input | 1 | Request comes from privileged code |
| altSel | input | 1 | Privileged request uses the alternate mode |
| pteAccess | input | 1 | Request is a page-table access |
| curMode | input | 2 | Current processor mode |
| altMode | input | 2 | Alternate processor mode |
| tbVpn | output | 51 | Virtual page number sent to the buffer |
| tbHit | input | 1 | Buffer hit for `tbVpn` |
| tbPpn | input | 32 | Physical page number of the hit entry |
| tbReadEn | input | 4 | Read enable, one bit per mode |
| tbWriteEn | input | 4 | Write enable, one bit per mode |
| tbFaultOnRead | input | 1 | Entry faults on read |
| tbFaultOnWrite | input | 1 | Entry faults on write |
| rspValid | output | 1 | Result present |
| paddr | output | 64 | Physical address (0 on fault) |
| fault | output | 3 | Fault kind code |
| status | output | 6 | Memory-management status bits |

## Verification
The bench stacks conditions on purpose so that ordering errors become visible. A misaligned address that is also invalid and in physical mode must still give an alignment fault; a design that checks validity first would report a page fault. A privileged request that runs in kernel through the override while the current mode is user must still be refused a superpage; a design that used the effective mode there would let it through. The two superpage extension cases, a page number wide enough to overflow the implemented width, and a load whose entry has a clear enable and fault-on-read set (violation kind, with both bits) each check a different point where a wrong bit choice or a wrong fault kind would show on the ports. The two miss kinds, and the opposite-direction fault-on bit that must be ignored, separate a design that mixes up the pte flag or the read and write fields.

// File: rtl/dtbx_pkg.sv
package dtbx_pkg;

  typedef enum logic [2:0] {
    FK_NONE     = 3'd0,
    FK_ALIGN    = 3'd1,
    FK_PAGE     = 3'd2,
    FK_ACV      = 3'd3,
    FK_MISS     = 3'd4,
    FK_MISS_PTE = 3'd5,
    FK_MCHK     = 3'd6
  } faultKind_e;

  localparam int STATUS_W = 6;
  localparam int ST_WRITE = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_BADVA = 2;
  localparam int ST_MISS  = 3;
  localparam int ST_FONR  = 4;
  localparam int ST_FONW  = 5;

  localparam logic [1:0] MODE_KERNEL = 2'd0;

  // Address-space layout the decoder depends on
  localparam int VA_SIGN_BIT  = 42;
  localparam int SP_TAG_HI    = 47;
  localparam int SP_TAG_LO    = 41;
  localparam logic [SP_TAG_HI-SP_TAG_LO:0] SP_TAG = 7'h7e;
  localparam int SP_EXT_BIT   = 40;
  localparam int SP_EXT_TOP   = 43;

  typedef enum logic [1:0] {
    PA_PHYS  = 2'd0,
    PA_SUPER = 2'd1,
    PA_PAGE  = 2'd2,
    PA_ZERO  = 2'd3
  } paSel_e;

  typedef struct packed {
    logic                capture;
    paSel_e              paSel;
    faultKind_e          fault;
    logic [STATUS_W-1:0] status;
  } ctrlStrobe_t;

  typedef struct packed {
    logic misaligned;
    logic vaValid;
    logic isSuper;
    logic paOverflow;
  } dpFlags_t;

endpackage

// File: rtl/dtbx_datapath.sv
module dtbx_datapath
  import dtbx_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PA_IMPL_W  = 44,
  parameter int PPN_W      = 32,
  parameter int PAGE_SHIFT = 13
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [VA_W-1:0]     vaddr,
  input  logic [1:0]          sizeLog2,
  input  logic [PPN_W-1:0]    ppn,
  input  logic                reqValid,
  input  ctrlStrobe_t         strobe,
  output dpFlags_t            flags,
  output logic                rspValid,
  output logic [VA_W-1:0]     paddr,
  output faultKind_e          fault,
  output logic [STATUS_W-1:0] status
);

  localparam int OFF_W = PAGE_SHIFT;

  logic [2:0]      byteMask;
  logic [VA_W-1:0] superPa;
  logic [VA_W-1:0] pagePa;
  logic [VA_W-1:0] selPa;
  logic [VA_W-VA_SIGN_BIT-1:0] signField;

  // Address-size decode: low-bit mask for the access width
  assign byteMask = 3'((4'd1 << sizeLog2) - 4'd1);

  assign signField = vaddr[VA_W-1:VA_SIGN_BIT];

  always_comb begin
    flags.misaligned = |(vaddr[2:0] & byteMask);
    flags.vaValid    = (&signField) | ~(|signField);
    flags.isSuper    = (vaddr[SP_TAG_HI:SP_TAG_LO] == SP_TAG);
  end

  // Superpage window: keep low bits, ones-extend through bit 43 when bit 40 set
  always_comb begin
    superPa = '0;
    superPa[SP_EXT_BIT-1:0] = vaddr[SP_EXT_BIT-1:0];
    if (vaddr[SP_EXT_BIT]) superPa[SP_EXT_TOP:SP_EXT_BIT] = '1;
  end

  // Page-number path for buffer hits
  always_comb begin
    pagePa = VA_W'(ppn) << PAGE_SHIFT;
    pagePa[OFF_W-1:0] = vaddr[OFF_W-1:0];
  end

  always_comb begin
    unique case (strobe.paSel)
      PA_PHYS:  selPa = vaddr;
      PA_SUPER: selPa = superPa;
      PA_PAGE:  selPa = pagePa;
      default:  selPa = '0;
    endcase
  end

  assign flags.paOverflow = |selPa[VA_W-1:PA_IMPL_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      paddr    <= '0;
      fault    <= FK_NONE;
      status   <= '0;
    end else begin
      rspValid <= reqValid;
      if (strobe.capture) begin
        fault  <= strobe.fault;
        status <= strobe.status;
        paddr  <= (strobe.fault == FK_NONE) ? selPa : '0;
      end
    end
  end

  a_r13_pa_zero_on_fault: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && fault != FK_NONE) |-> (paddr == '0));

  a_r12_mchk_clean_status: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && fault == FK_MCHK) |-> (status == '0));

endmodule

// File: rtl/dtbx_control.sv
module dtbx_control
  import dtbx_pkg::*;
(
  input  logic        reqValid,
  input  logic        isWrite,
  input  logic        physMode,
  input  logic        palCode,
  input  logic        altSel,
  input  logic        pteAccess,
  input  logic [1:0]  curMode,
  input  logic [1:0]  altMode,
  input  logic        tbHit,
  input  logic [3:0]  tbReadEn,
  input  logic [3:0]  tbWriteEn,
  input  logic        tbFaultOnRead,
  input  logic        tbFaultOnWrite,
  input  dpFlags_t    flags,
  output ctrlStrobe_t strobe
);

  logic [1:0]          effMode;
  logic [STATUS_W-1:0] wrBit;
  faultKind_e          preFault;
  logic [STATUS_W-1:0] preStatus;

  always_comb begin
    if (palCode) effMode = altSel ? altMode : MODE_KERNEL;
    else         effMode = curMode;
  end

  always_comb begin
    wrBit = '0;
    wrBit[ST_WRITE] = isWrite;
  end

  // Ordered checks; the first one that fires wins
  always_comb begin
    preFault     = FK_NONE;
    preStatus    = '0;
    strobe.paSel = PA_ZERO;
    if (flags.misaligned) begin
      preFault  = FK_ALIGN;
      preStatus = wrBit;
    end else if (physMode) begin
      strobe.paSel = PA_PHYS;
    end else if (!flags.vaValid) begin
      preFault  = FK_PAGE;
      preStatus = wrBit;
      preStatus[ST_BADVA] = 1'b1;
      preStatus[ST_ACV]   = 1'b1;
    end else if (flags.isSuper) begin
      if (curMode != MODE_KERNEL) begin
        preFault  = FK_ACV;
        preStatus = wrBit;
        preStatus[ST_ACV] = 1'b1;
      end else begin
        strobe.paSel = PA_SUPER;
      end
    end else if (!tbHit) begin
      preFault  = pteAccess ? FK_MISS_PTE : FK_MISS;
      preStatus = wrBit;
      preStatus[ST_MISS] = 1'b1;
    end else begin
      strobe.paSel = PA_PAGE;
      if (isWrite) begin
        if (!tbWriteEn[effMode]) begin
          preFault  = FK_PAGE;
          preStatus[ST_WRITE] = 1'b1;
          preStatus[ST_ACV]   = 1'b1;
          preStatus[ST_FONW]  = tbFaultOnWrite;
        end else if (tbFaultOnWrite) begin
          preFault  = FK_PAGE;
          preStatus[ST_WRITE] = 1'b1;
          preStatus[ST_FONW]  = 1'b1;
        end
      end else begin
        if (!tbReadEn[effMode]) begin
          preFault  = FK_ACV;
          preStatus[ST_ACV]  = 1'b1;
          preStatus[ST_FONR] = tbFaultOnRead;
        end else if (tbFaultOnRead) begin
          preFault  = FK_PAGE;
          preStatus[ST_FONR] = 1'b1;
        end
      end
    end
  end

  // Final physical-width check applies only to an otherwise clean access
  always_comb begin
    strobe.capture = reqValid;
    strobe.fault   = preFault;
    strobe.status  = preStatus;
    if (preFault == FK_NONE && flags.paOverflow) begin
      strobe.fault  = FK_MCHK;
      strobe.status = '0;
    end
  end

endmodule

// File: rtl/dtb_fault_prioritizer.sv
module dtb_fault_prioritizer
  import dtbx_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PA_IMPL_W  = 44,
  parameter int PPN_W      = 32,
  parameter int PAGE_SHIFT = 13
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic [VA_W-1:0]            vaddr,
  input  logic [1:0]                 sizeLog2,
  input  logic                       isWrite,
  input  logic                       physMode,
  input  logic                       palCode,
  input  logic                       altSel,
  input  logic                       pteAccess,
  input  logic [1:0]                 curMode,
  input  logic [1:0]                 altMode,
  output logic [VA_W-PAGE_SHIFT-1:0] tbVpn,
  input  logic                       tbHit,
  input  logic [PPN_W-1:0]           tbPpn,
  input  logic [3:0]                 tbReadEn,
  input  logic [3:0]                 tbWriteEn,
  input  logic                       tbFaultOnRead,
  input  logic                       tbFaultOnWrite,
  output logic                       rspValid,
  output logic [VA_W-1:0]            paddr,
  output logic [2:0]                 fault,
  output logic [STATUS_W-1:0]        status
);

  ctrlStrobe_t strobe;
  dpFlags_t    flags;
  faultKind_e  faultQ;

  assign tbVpn = vaddr[VA_W-1:PAGE_SHIFT];
  assign fault = faultQ;

  dtbx_control i_control (
    .reqValid      (reqValid),
    .isWrite       (isWrite),
    .physMode      (physMode),
    .palCode       (palCode),
    .altSel        (altSel),
    .pteAccess     (pteAccess),
    .curMode       (curMode),
    .altMode       (altMode),
    .tbHit         (tbHit),
    .tbReadEn      (tbReadEn),
    .tbWriteEn     (tbWriteEn),
    .tbFaultOnRead (tbFaultOnRead),
    .tbFaultOnWrite(tbFaultOnWrite),
    .flags         (flags),
    .strobe        (strobe)
  );

  dtbx_datapath #(
    .VA_W      (VA_W),
    .PA_IMPL_W (PA_IMPL_W),
    .PPN_W     (PPN_W),
    .PAGE_SHIFT(PAGE_SHIFT)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .vaddr   (vaddr),
    .sizeLog2(sizeLog2),
    .ppn     (tbPpn),
    .reqValid(reqValid),
    .strobe  (strobe),
    .flags   (flags),
    .rspValid(rspValid),
    .paddr   (paddr),
    .fault   (faultQ),
    .status  (status)
  );

  a_r1_response_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r2_align_first: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && flags.misaligned) |=> (faultQ == FK_ALIGN));

  a_r7_miss_kind: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !flags.misaligned && !physMode && flags.vaValid &&
     !flags.isSuper && !tbHit)
    |=> ((faultQ == FK_MISS || faultQ == FK_MISS_PTE) && status[ST_MISS]));

  a_r10_load_no_write_bit: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !isWrite) |=> !status[ST_WRITE]);

endmodule

// File: tb/test_dtb_fault_prioritizer.sv
module test_dtb_fault_prioritizer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid, isWrite, physMode, palCode, altSel, pteAccess;
  logic [63:0] vaddr;
  logic [1:0]  sizeLog2, curMode, altMode;
  logic [50:0] tbVpn;
  logic        tbHit, tbFaultOnRead, tbFaultOnWrite;
  logic [31:0] tbPpn;
  logic [3:0]  tbReadEn, tbWriteEn;
  logic        rspValid;
  logic [63:0] paddr;
  logic [2:0]  fault;
  logic [5:0]  status;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtb_fault_prioritizer i_dtb_fault_prioritizer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .vaddr(vaddr),
    .sizeLog2(sizeLog2), .isWrite(isWrite), .physMode(physMode),
    .palCode(palCode), .altSel(altSel), .pteAccess(pteAccess),
    .curMode(curMode), .altMode(altMode), .tbVpn(tbVpn), .tbHit(tbHit),
    .tbPpn(tbPpn), .tbReadEn(tbReadEn), .tbWriteEn(tbWriteEn),
    .tbFaultOnRead(tbFaultOnRead), .tbFaultOnWrite(tbFaultOnWrite),
    .rspValid(rspValid), .paddr(paddr), .fault(fault), .status(status)
  );

  task automatic expectEq(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = 0; vaddr = 64'h0; sizeLog2 = 2'd3; isWrite = 0; physMode = 0;
    palCode = 0; altSel = 0; pteAccess = 0; curMode = 2'd0; altMode = 2'd0;
    tbHit = 0; tbPpn = 32'h0; tbReadEn = 4'hF; tbWriteEn = 4'hF;
    tbFaultOnRead = 0; tbFaultOnWrite = 0;
  endtask

  // Fire one request at a falling edge, sample the result after the next rising edge
  task automatic fireAndCheck(string req, logic [2:0] expFault, logic [5:0] expStatus,
                              logic [63:0] expPa);
    reqValid = 1;
    @(posedge clk);
    @(negedge clk);
    expectEq(req, "rspValid", 64'(rspValid), 64'd1);
    expectEq(req, "fault", 64'(fault), 64'(expFault));
    expectEq(req, "status", 64'(status), 64'(expStatus));
    expectEq(req, "paddr", paddr, expPa);
    idle();
  endtask

  task automatic testReset();
    expectEq("R1", "rspValid", 64'(rspValid), 64'd0);
    expectEq("R1", "fault", 64'(fault), 64'd0);
    expectEq("R1", "status", 64'(status), 64'd0);
    expectEq("R1", "paddr", paddr, 64'd0);
  endtask

  task automatic testAlign();
    vaddr = 64'h1002; sizeLog2 = 2'd2; isWrite = 1;
    fireAndCheck("R2", 3'd1, 6'h01, 64'h0);
    // misaligned, invalid and physical at once: alignment still wins
    vaddr = 64'h0000_0800_0000_0001; sizeLog2 = 2'd1; physMode = 1;
    fireAndCheck("R2", 3'd1, 6'h00, 64'h0);
    // byte access never misaligned
    vaddr = 64'h7; sizeLog2 = 2'd0; physMode = 1;
    fireAndCheck("R2", 3'd0, 6'h00, 64'h7);
  endtask

  task automatic testPhys();
    vaddr = 64'h0000_0123_4567_89A8; physMode = 1;
    fireAndCheck("R3", 3'd0, 6'h00, 64'h0000_0123_4567_89A8);
    vaddr = 64'h0004_0000_0000_0000; physMode = 1;
    fireAndCheck("R12", 3'd6, 6'h00, 64'h0);
  endtask

  task automatic testInvalid();
    vaddr = 64'h0000_0800_0000_0000;
    fireAndCheck("R4", 3'd2, 6'h06, 64'h0);
    vaddr = 64'h0000_0800_0000_0000; isWrite = 1;
    fireAndCheck("R4", 3'd2, 6'h07, 64'h0);
  endtask

  task automatic testSuper();
    vaddr = 64'hFFFF_FC12_3456_7008;
    fireAndCheck("R6", 3'd0, 6'h00, 64'h0000_0012_3456_7008);
    vaddr = 64'hFFFF_FD12_3456_7008;
    fireAndCheck("R6", 3'd0, 6'h00, 64'h0000_0F12_3456_7008);
    vaddr = 64'hFFFF_FC12_3456_7008; curMode = 2'd3;
    fireAndCheck("R5", 3'd3, 6'h02, 64'h0);
    vaddr = 64'hFFFF_FC12_3456_7008; curMode = 2'd1; isWrite = 1;
    fireAndCheck("R5", 3'd3, 6'h03, 64'h0);
    // effective mode kernel by override, current mode user: still refused
    vaddr = 64'hFFFF_FC12_3456_7008; curMode = 2'd3; palCode = 1; altSel = 0;
    fireAndCheck("R5", 3'd3, 6'h02, 64'h0);
  endtask

  task automatic testMiss();
    vaddr = 64'h2000;
    fireAndCheck("R7", 3'd4, 6'h08, 64'h0);
    vaddr = 64'h2000; isWrite = 1; pteAccess = 1;
    fireAndCheck("R7", 3'd5, 6'h09, 64'h0);
  endtask

  task automatic testHit();
    vaddr = 64'h0000_0000_0040_1AB8; tbHit = 1; tbPpn = 32'h0001_2345;
    tbReadEn = 4'b0001;
    #1 expectEq("R8", "tbVpn", 64'(tbVpn), 64'h200);
    fireAndCheck("R8", 3'd0, 6'h00, 64'h0000_0000_2468_BAB8);
    vaddr = 64'h4000; tbHit = 1; tbPpn = 32'hFFFF_FFFF;
    fireAndCheck("R12", 3'd6, 6'h00, 64'h0);
  endtask

  task automatic testWritePerm();
    vaddr = 64'h4000; isWrite = 1; tbHit = 1; tbPpn = 32'h10;
    curMode = 2'd3; tbWriteEn = 4'b0001; tbFaultOnWrite = 1;
    fireAndCheck("R9", 3'd2, 6'h23, 64'h0);
    vaddr = 64'h4000; isWrite = 1; tbHit = 1; tbPpn = 32'h10;
    curMode = 2'd3; tbWriteEn = 4'b0001;
    fireAndCheck("R9", 3'd2, 6'h03, 64'h0);
    vaddr = 64'h4000; isWrite = 1; tbHit = 1; tbPpn = 32'h10; tbFaultOnWrite = 1;
    fireAndCheck("R9", 3'd2, 6'h21, 64'h0);
    // fault-on-read ignored for a permitted store
    vaddr = 64'h4010; isWrite = 1; tbHit = 1; tbPpn = 32'h10; tbFaultOnRead = 1;
    fireAndCheck("R13", 3'd0, 6'h00, 64'h0002_0010);
  endtask

  task automatic testReadPerm();
    vaddr = 64'h4000; tbHit = 1; tbPpn = 32'h10; curMode = 2'd3;
    tbReadEn = 4'b0001; tbFaultOnRead = 1;
    fireAndCheck("R10", 3'd3, 6'h12, 64'h0);
    vaddr = 64'h4000; tbHit = 1; tbPpn = 32'h10; tbFaultOnRead = 1;
    fireAndCheck("R10", 3'd2, 6'h10, 64'h0);
    // fault-on-write ignored for a permitted load
    vaddr = 64'h4008; tbHit = 1; tbPpn = 32'h10; tbFaultOnWrite = 1;
    fireAndCheck("R13", 3'd0, 6'h00, 64'h0002_0008);
  endtask

  task automatic testEffMode();
    vaddr = 64'h4000; tbHit = 1; tbPpn = 32'h10; tbReadEn = 4'b0001;
    palCode = 1; altSel = 1; altMode = 2'd3; curMode = 2'd0;
    fireAndCheck("R11", 3'd3, 6'h02, 64'h0);
    vaddr = 64'h4000; tbHit = 1; tbPpn = 32'h10; tbReadEn = 4'b0001;
    palCode = 1; altSel = 0; curMode = 2'd3;
    fireAndCheck("R11", 3'd0, 6'h00, 64'h0002_0000);
    vaddr = 64'h4000; tbHit = 1; tbPpn = 32'h10; tbReadEn = 4'b0100;
    curMode = 2'd2;
    fireAndCheck("R11", 3'd0, 6'h00, 64'h0002_0000);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testAlign();
    testPhys();
    testInvalid();
    testSuper();
    testMiss();
    testHit();
    testWritePerm();
    testReadPerm();
    testEffMode();
    @(negedge clk);
    expectEq("R1", "rspValid idle", 64'(rspValid), 64'd0);
    finishRun();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    finishRun();
  end

endmodule